// File: doc/BRIEF.md
# I2S Stereo Receiver with Bit-Clock Ratio Detection

This block takes a three-wire I2S-style audio stream (bit clock, word select and serial data) and turns it into parallel 24-bit left and right samples in the system clock domain. All three serial lines pass through two-flop synchronisers. The bit clock is sampled with the system clock, and only its rising edges are used to take in word select and data.

The receiver counts bit clocks over each full word-select period and works out whether the frame carries 32, 48 or 64 bits. It needs no setting for this. Each channel word is placed MSB-aligned in a 24-bit result. Bits beyond the 24th are dropped, and positions the frame never carries are zero. A left/right pair is published together with a single valid pulse once the right-channel slot has ended. A frame of any other length raises a sticky error flag and publishes nothing. The system clock must run at least four times faster than the bit clock.

Top module: `i2s_rx_auto`

## Requirements
- R1: Word select low marks a left-channel slot and high marks a right-channel slot, so the left word appears on `left_o` and the right word on `right_o`.
- R2: A channel word's first bit (its MSB) is taken at the bit-clock rising edge one period after word select changes level. The last bit of a slot is taken at the rising edge where word select has already changed.
- R3: At 64 bit clocks per frame (32-bit slots), only the first 24 bits of a slot reach the output. The trailing 8 bits have no effect.
- R4: At 48 bit clocks per frame (24-bit slots), all 24 bits of the slot appear on the output, MSB first.
- R5: At 32 bit clocks per frame (16-bit slots), the 16 received bits fill output bits 23:8 and bits 7:0 are zero.
- R6: `ratio_o` reports the length of the last good frame: 2'b01 for 32, 2'b10 for 48 and 2'b11 for 64. It reads 2'b00 after reset, before any good frame.
- R7: A frame whose length is not 32, 48 or 64 bit clocks sets `frame_err_o`, which stays set until reset. Such a frame does not pulse `valid_o` and does not change the outputs.
- R8: `valid_o` pulses for exactly one system clock after the right slot of each good frame ends, and the sample outputs change only in that cycle.
- R9: After reset, the first complete frame is discarded. The first valid pulse comes from the second frame.
- R10: While reset is held, the sample outputs, `ratio_o`, `valid_o` and `frame_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_i | input | 1 | Serial bit clock, asynchronous |
| ws_i | input | 1 | Word select, low for left and high for right |
| sd_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Left sample, MSB-aligned |
| right_o | output | 24 | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle pulse when a new pair is on the outputs |
| ratio_o | output | 2 | Detected bit clocks per frame of the last good frame |
| frame_err_o | output | 1 | Sticky flag for a frame of unsupported length |

## Verification
The hardest case to reach is the one where a slot's last bit is taken while word select already shows the other channel. At 32 bits per frame this bit is the right word's LSB, and it lands inside the published 16 bits. The stimulus task sends every frame with that last bit placed after the word-select change, and it uses distinct bit patterns at each slot edge, so a receiver that misplaces the boundary produces wrong low bits. A deliberately short frame drives the error path, and a good frame sent after it shows that the flag stays set while output resumes.

// File: rtl/i2s_rx_auto.sv
module i2s_rx_auto #(
  parameter int DW = 24,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_i,
  input  logic          ws_i,
  input  logic          sd_i,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          valid_o,
  output logic [1:0]    ratio_o,
  output logic          frame_err_o
);
  localparam logic [CW-1:0] LEN32 = CW'(32);
  localparam logic [CW-1:0] LEN48 = CW'(48);
  localparam logic [CW-1:0] LEN64 = CW'(64);
  localparam logic [CW-1:0] CMAX  = '1;

  logic [2:0] sck_s;
  logic [1:0] ws_s, sd_s;
  logic primed, framed, ws_prev, pend;
  logic [CW-1:0] bcnt, fcnt, plen;
  logic [DW-1:0] sh_l, sh_r;

  wire rise   = sck_s[1] & ~sck_s[2];
  wire ws     = ws_s[1];
  wire sd     = sd_s[1];
  wire change = ws != ws_prev;
  wire f_end  = primed && change && !ws;
  wire [CW-1:0] bnext = (bcnt == CMAX) ? bcnt : bcnt + 1'b1;
  wire [CW-1:0] fnext = (fcnt == CMAX) ? fcnt : fcnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_s <= '0;
      ws_s  <= '0;
      sd_s  <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      ws_s  <= {ws_s[0], ws_i};
      sd_s  <= {sd_s[0], sd_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      framed  <= 1'b0;
      ws_prev <= 1'b0;
      pend    <= 1'b0;
      bcnt    <= CMAX;
      fcnt    <= '0;
      plen    <= '0;
      sh_l    <= '0;
      sh_r    <= '0;
    end else begin
      pend <= 1'b0;
      if (rise) begin
        ws_prev <= ws;
        if (!primed) begin
          primed <= 1'b1;
          bcnt   <= CMAX;
        end else begin
          if (bcnt < CW'(DW)) begin
            if (!ws_prev) begin
              if (bcnt == '0) sh_l <= {sd, {(DW-1){1'b0}}};
              else            sh_l[DW-1-int'(bcnt)] <= sd;
            end else begin
              if (bcnt == '0) sh_r <= {sd, {(DW-1){1'b0}}};
              else            sh_r[DW-1-int'(bcnt)] <= sd;
            end
          end
          bcnt <= change ? '0 : bnext;
          if (f_end) begin
            framed <= 1'b1;
            pend   <= framed;
            plen   <= fnext;
            fcnt   <= '0;
          end else begin
            fcnt <= fnext;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
      ratio_o     <= 2'b00;
      frame_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (pend) begin
        if (plen == LEN32 || plen == LEN48 || plen == LEN64) begin
          left_o  <= sh_l;
          right_o <= sh_r;
          valid_o <= 1'b1;
          ratio_o <= (plen == LEN32) ? 2'b01 : (plen == LEN48) ? 2'b10 : 2'b11;
        end else begin
          frame_err_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2s_rx_auto_chk.sv
module i2s_rx_auto_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] left_o,
  input logic [DW-1:0] right_o,
  input logic          valid_o,
  input logic [1:0]    ratio_o,
  input logic          frame_err_o
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) valid_o |=> !valid_o); // R8
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n) !valid_o |-> ($stable(left_o) && $stable(right_o))); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) frame_err_o |=> frame_err_o); // R7
  AST_NARROW_LOW: assert property (@(posedge clk) disable iff (!rst_n) (valid_o && ratio_o == 2'b01) |-> (left_o[7:0] == 8'h00 && right_o[7:0] == 8'h00)); // R5
  AST_VALID_RATIO: assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> ratio_o != 2'b00); // R6
endmodule

bind i2s_rx_auto i2s_rx_auto_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .left_o(left_o), .right_o(right_o),
  .valid_o(valid_o), .ratio_o(ratio_o), .frame_err_o(frame_err_o)
);

// File: tb/i2s_rx_auto_tb_top.sv
module i2s_rx_auto_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [23:0] left_o, right_o;
  logic valid_o, frame_err_o;
  logic [1:0] ratio_o;
  int checks = 0, errors = 0, vcnt = 0;

  always #2 clk = ~clk;

  i2s_rx_auto dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .ratio_o(ratio_o), .frame_err_o(frame_err_o)
  );

  always @(posedge clk) if (rst_n && valid_o) vcnt <= vcnt + 1;

  localparam int NV = 6;
  localparam int T_N [NV] = '{64, 48, 32, 64, 32, 48};
  localparam logic [31:0] T_L [NV] = '{32'hA5C3_0F81, 32'h8000_01FF, 32'h1234_FFFF, 32'hFFFF_FE7E, 32'h8001_0001, 32'h0000_0100};
  localparam logic [31:0] T_R [NV] = '{32'h5A3C_F07E, 32'h7FFF_FE00, 32'hFEDC_0001, 32'h0000_01FF, 32'h7FFE_8001, 32'hFFFF_FFFF};

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp24(logic [31:0] w, int n);
    return (n == 32) ? {w[31:16], 8'h00} : w[31:8];
  endfunction

  function automatic logic [1:0] code(int n);
    return (n == 32) ? 2'b01 : (n == 48) ? 2'b10 : 2'b11;
  endfunction

  task automatic send_bit(logic w, logic d);
    @(negedge clk); sck = 1'b0; ws = w; sd = d;
    repeat (5) @(negedge clk);
    sck = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_frame(int n, logic [31:0] l, logic [31:0] r);
    int slot = n / 2;
    for (int i = 1; i < n; i++) begin
      int j = i - 1;
      send_bit(i >= slot, (j < slot) ? l[31-j] : r[31-(j-slot)]);
    end
    send_bit(1'b0, r[31-(slot-1)]);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v0;
    logic [23:0] hl, hr;
    repeat (4) @(negedge clk);
    check("R10 reset outputs", {left_o, right_o}, 48'h0);
    check("R10 reset flags", {44'h0, valid_o, ratio_o, frame_err_o}, 48'h0);
    rst_n = 1'b1;
    send_bit(1'b0, 1'b0);
    send_frame(64, 32'hDEAD_BEEF, 32'hCAFE_F00D);
    check("R9 first frame discarded", vcnt, 0);
    check("R9 outputs untouched", {left_o, right_o}, 48'h0);
    check("R6 no ratio yet", ratio_o, 2'b00);

    for (int k = 0; k < NV; k++) begin
      v0 = vcnt;
      send_frame(T_N[k], T_L[k], T_R[k]);
      check("R8 one valid per frame", vcnt - v0, 1);
      check((T_N[k] == 64) ? "R1 R3 left" : (T_N[k] == 48) ? "R1 R4 left" : "R1 R5 left", left_o, exp24(T_L[k], T_N[k]));
      check("R2 right MSB-first with late LSB", right_o, exp24(T_R[k], T_N[k]));
      check("R6 ratio code", ratio_o, code(T_N[k]));
      check("R7 no error on good frame", frame_err_o, 1'b0);
    end

    hl = left_o; hr = right_o; v0 = vcnt;
    send_frame(40, 32'h1111_1111, 32'h2222_2222);
    check("R7 bad frame no valid", vcnt - v0, 0);
    check("R7 error flag set", frame_err_o, 1'b1);
    check("R7 outputs unchanged", {left_o, right_o}, {hl, hr});
    check("R7 ratio kept", ratio_o, 2'b10);

    v0 = vcnt;
    send_frame(32, 32'hBEEF_0000, 32'h0001_FFFF);
    check("R8 resume after error", vcnt - v0, 1);
    check("R5 narrow pair", {left_o, right_o}, {24'hBEEF00, 24'h000100});
    check("R7 error sticky", frame_err_o, 1'b1);

    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset clears outputs", {left_o, right_o}, 48'h0);
    check("R10 reset clears flags", {44'h0, valid_o, ratio_o, frame_err_o}, 48'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule